// File: doc/BRIEF.md
# Regional Congestion Level Aggregator

This unit sits beside one router of a two-dimensional mesh. It gives that router a view of how congested each of the four quadrants around it is: north-east, north-west, south-west and south-east. Each cycle it builds a local congestion figure from two sources. The first is the number of occupied virtual channels across all input ports. The second is the crossbar demand, which is the number of packets contending for the same output port. It then merges that figure with the levels reported by its mesh neighbours over 9-bit sideband links.

Each quadrant is bounded by two directions. The quadrant level takes the weighted local figure plus the weighted larger of the two neighbour values on those bounding sides. The weights are power-of-two shifts, and the sum saturates at 511. Each neighbour is then sent a registered summary of the quadrants that lie beyond this router as seen from that neighbour. In this way congestion information travels one hop per cycle across the mesh.

The four quadrant levels are also exported as a packed vector for a memory controller attached to the router. A per-quadrant "congested" flag is raised when a level is at or above a programmable threshold. A neighbour that does not exist at the edge of the mesh is declared at elaboration, and its link is read as zero congestion.

Top module: `regional_cong_agg`

## Requirements
- R1: While `rst` is high at a clock edge, every output (all quadrant levels, all flags and all four sideband outputs) is zero after that edge, whatever the inputs.
- R2: The local figure is the number of set bits in `vc_busy` plus `xb_demand`, clamped to 511 when the sum exceeds 9 bits.
- R3: Each quadrant level equals (local >> LOCAL_SHIFT) + (max of its two bounding neighbour inputs >> NBR_SHIFT). The bounding inputs are: NE from north and east, NW from north and west, SW from south and west, SE from south and east. In `quad_level`, NE sits in bits [8:0], NW in [17:9], SW in [26:18] and SE in [35:27].
- R4: A quadrant level whose weighted sum exceeds 511 reads 511.
- R5: The input from a neighbour whose bit in NBR_PRESENT is clear has no effect on any output. The bits are 0 = north, 1 = east, 2 = south, 3 = west.
- R6: Each sideband output carries the larger of two quadrant levels. North receives max(SW, SE), east receives max(NW, SW), south receives max(NE, NW) and west receives max(NE, SE).
- R7: `quad_hot` bit q is 1 exactly when quadrant level q is greater than or equal to `threshold`. The bit order is 0 = NE, 1 = NW, 2 = SW, 3 = SE.
- R8: All outputs are registered. A change on any input shows at the outputs after the next rising edge and not before, and steady inputs leave the outputs steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vc_busy | input | NUM_PORTS*VC_PER_PORT | One bit per virtual channel, set when occupied |
| xb_demand | input | XB_W | Number of packets contending for one output port |
| nbr_in_n | input | 9 | Level reported by the north neighbour |
| nbr_in_e | input | 9 | Level reported by the east neighbour |
| nbr_in_s | input | 9 | Level reported by the south neighbour |
| nbr_in_w | input | 9 | Level reported by the west neighbour |
| threshold | input | 9 | Level at or above which a quadrant is flagged |
| nbr_out_n | output | 9 | Registered level sent to the north neighbour |
| nbr_out_e | output | 9 | Registered level sent to the east neighbour |
| nbr_out_s | output | 9 | Registered level sent to the south neighbour |
| nbr_out_w | output | 9 | Registered level sent to the west neighbour |
| quad_level | output | 36 | Registered quadrant levels for the memory controller |
| quad_hot | output | 4 | Registered per-quadrant congested flags |

## Verification
The bench builds the block with a 9-bit crossbar demand input, LOCAL_SHIFT of 0, NBR_SHIFT of 1 and the west neighbour marked absent. The wide demand input lets the local figure exceed 511, so the clamp on the local sum can be reached. The unshifted local term lets a quadrant sum pass 511, so the output saturation can be reached as well. With the west neighbour absent, a large value on the west link must leave the north-west and south-west levels untouched. Thresholds are placed exactly on a level and one above it to pin down the inclusive compare.

// File: rtl/rca_pkg.sv
package rca_pkg;

    localparam int LVL_W   = 9;
    localparam int LVL_MAX = (1 << LVL_W) - 1;
    localparam int NUM_DIR = 4;
    localparam int NUM_Q   = 4;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef lvl_t [NUM_DIR-1:0] dir_vec_t;
    typedef lvl_t [NUM_Q-1:0]   quad_vec_t;

    // Direction indices, also the bit order of the neighbour-present mask.
    localparam int D_N = 0;
    localparam int D_E = 1;
    localparam int D_S = 2;
    localparam int D_W = 3;

    // Quadrant indices, also the field and flag order at the ports.
    localparam int Q_NE = 0;
    localparam int Q_NW = 1;
    localparam int Q_SW = 2;
    localparam int Q_SE = 3;

    // The two directions that bound a quadrant.
    function automatic int quad_side_a(int q);
        return (q == Q_NE || q == Q_NW) ? D_N : D_S;
    endfunction

    function automatic int quad_side_b(int q);
        return (q == Q_NE || q == Q_SE) ? D_E : D_W;
    endfunction

    // The two quadrants lying beyond this router as seen from neighbour d.
    function automatic int far_quad_a(int d);
        case (d)
            D_N:     return Q_SW;
            D_E:     return Q_NW;
            D_S:     return Q_NE;
            default: return Q_NE;
        endcase
    endfunction

    function automatic int far_quad_b(int d);
        case (d)
            D_N:     return Q_SE;
            D_E:     return Q_SW;
            D_S:     return Q_NW;
            default: return Q_SE;
        endcase
    endfunction

    function automatic lvl_t lvl_max(lvl_t a, lvl_t b);
        return (a > b) ? a : b;
    endfunction

    // Add two levels, clamping at the largest representable level.
    function automatic lvl_t lvl_sat_add(lvl_t a, lvl_t b);
        logic [LVL_W:0] sum;
        sum = {1'b0, a} + {1'b0, b};
        return sum[LVL_W] ? lvl_t'(LVL_MAX) : sum[LVL_W-1:0];
    endfunction

endpackage

// File: rtl/rca_local_metric.sv
module rca_local_metric
    import rca_pkg::*;
#(
    parameter int NUM_VC = 20,
    parameter int XB_W   = 5
) (
    input  logic [NUM_VC-1:0] vc_busy,
    input  logic [XB_W-1:0]   xb_demand,
    output lvl_t              metric
);

    localparam int CNT_W = $clog2(NUM_VC + 1);
    localparam int SUM_W = ((CNT_W > XB_W) ? CNT_W : XB_W) + 1;

    logic [CNT_W-1:0] busy_cnt;
    logic [SUM_W-1:0] raw_sum;

    always_comb begin
        busy_cnt = '0;
        for (int i = 0; i < NUM_VC; i++) begin
            busy_cnt = busy_cnt + CNT_W'(vc_busy[i]);
        end
    end

    assign raw_sum = SUM_W'(busy_cnt) + SUM_W'(xb_demand);

    // Clamp the local figure into the sideband level width (R2).
    generate
        if (SUM_W > LVL_W) begin : g_clamp
            assign metric = (raw_sum > SUM_W'(LVL_MAX)) ? lvl_t'(LVL_MAX)
                                                         : raw_sum[LVL_W-1:0];
        end else begin : g_fit
            assign metric = lvl_t'(raw_sum);
        end
    endgenerate

endmodule

// File: rtl/rca_quad_merge.sv
module rca_quad_merge
    import rca_pkg::*;
#(
    parameter int         LOCAL_SHIFT = 1,
    parameter int         NBR_SHIFT   = 1,
    parameter logic [3:0] NBR_PRESENT = 4'b1111
) (
    input  lvl_t      local_metric,
    input  dir_vec_t  nbr_in,
    output quad_vec_t level_next
);

    dir_vec_t nbr_live;
    lvl_t     local_term;

    // Missing neighbours contribute zero congestion (R5).
    for (genvar d = 0; d < NUM_DIR; d++) begin : g_mask
        assign nbr_live[d] = nbr_in[d] & {LVL_W{NBR_PRESENT[d]}};
    end

    assign local_term = local_metric >> LOCAL_SHIFT;

    // Per-quadrant weighted merge with saturation (R3, R4).
    for (genvar q = 0; q < NUM_Q; q++) begin : g_quad
        localparam int SA = quad_side_a(q);
        localparam int SB = quad_side_b(q);
        lvl_t nbr_worst;
        lvl_t nbr_term;
        assign nbr_worst     = lvl_max(nbr_live[SA], nbr_live[SB]);
        assign nbr_term      = nbr_worst >> NBR_SHIFT;
        assign level_next[q] = lvl_sat_add(local_term, nbr_term);
    end

endmodule

// File: rtl/rca_out_stage.sv
module rca_out_stage
    import rca_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  quad_vec_t  level_next,
    input  lvl_t       threshold,
    output quad_vec_t  level_q,
    output logic [3:0] hot_q,
    output dir_vec_t   sb_q
);

    logic [3:0] hot_next;
    dir_vec_t   sb_next;

    for (genvar q = 0; q < NUM_Q; q++) begin : g_flag
        assign hot_next[q] = (level_next[q] >= threshold);
    end

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_sb
        assign sb_next[d] = lvl_max(level_next[far_quad_a(d)],
                                    level_next[far_quad_b(d)]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
            hot_q   <= '0;
            sb_q    <= '0;
        end else begin
            level_q <= level_next;
            hot_q   <= hot_next;
            sb_q    <= sb_next;
        end
    end

    for (genvar q = 0; q < NUM_Q; q++) begin : g_chk
        AST_FLAG_TRACKS_LEVEL: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> (hot_q[q] == (level_q[q] >= $past(threshold))));  // R7
    end

    AST_SB_NORTH_FAR: assert property (@(posedge clk) disable iff (rst)
        sb_q[D_N] == lvl_max(level_q[Q_SW], level_q[Q_SE]));  // R6

endmodule

// File: rtl/regional_cong_agg.sv
module regional_cong_agg
    import rca_pkg::*;
#(
    parameter int         VC_PER_PORT = 4,
    parameter int         NUM_PORTS   = 5,
    parameter int         XB_W        = 5,
    parameter int         LOCAL_SHIFT = 1,
    parameter int         NBR_SHIFT   = 1,
    parameter logic [3:0] NBR_PRESENT = 4'b1111
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_PORTS*VC_PER_PORT-1:0] vc_busy,
    input  logic [XB_W-1:0]                xb_demand,
    input  logic [8:0]                     nbr_in_n,
    input  logic [8:0]                     nbr_in_e,
    input  logic [8:0]                     nbr_in_s,
    input  logic [8:0]                     nbr_in_w,
    input  logic [8:0]                     threshold,
    output logic [8:0]                     nbr_out_n,
    output logic [8:0]                     nbr_out_e,
    output logic [8:0]                     nbr_out_s,
    output logic [8:0]                     nbr_out_w,
    output logic [35:0]                    quad_level,
    output logic [3:0]                     quad_hot
);

    localparam int NUM_VC = NUM_PORTS * VC_PER_PORT;

    lvl_t      local_metric;
    dir_vec_t  nbr_in_v;
    quad_vec_t level_next;
    quad_vec_t level_q;
    dir_vec_t  sb_q;

    assign nbr_in_v[D_N] = nbr_in_n;
    assign nbr_in_v[D_E] = nbr_in_e;
    assign nbr_in_v[D_S] = nbr_in_s;
    assign nbr_in_v[D_W] = nbr_in_w;

    rca_local_metric #(
        .NUM_VC (NUM_VC),
        .XB_W   (XB_W)
    ) u_metric (
        .vc_busy   (vc_busy),
        .xb_demand (xb_demand),
        .metric    (local_metric)
    );

    rca_quad_merge #(
        .LOCAL_SHIFT (LOCAL_SHIFT),
        .NBR_SHIFT   (NBR_SHIFT),
        .NBR_PRESENT (NBR_PRESENT)
    ) u_merge (
        .local_metric (local_metric),
        .nbr_in       (nbr_in_v),
        .level_next   (level_next)
    );

    rca_out_stage u_out (
        .clk        (clk),
        .rst        (rst),
        .level_next (level_next),
        .threshold  (threshold),
        .level_q    (level_q),
        .hot_q      (quad_hot),
        .sb_q       (sb_q)
    );

    assign quad_level = level_q;
    assign nbr_out_n  = sb_q[D_N];
    assign nbr_out_e  = sb_q[D_E];
    assign nbr_out_s  = sb_q[D_S];
    assign nbr_out_w  = sb_q[D_W];

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (quad_level == '0 && quad_hot == '0));  // R1

    AST_HOLD_WHEN_STEADY: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(vc_busy) && $stable(xb_demand) &&
         $stable(nbr_in_n) && $stable(nbr_in_e) && $stable(nbr_in_s) &&
         $stable(nbr_in_w) && $stable(threshold))
        |=> ($stable(quad_level) && $stable(quad_hot)));  // R8

    for (genvar q = 0; q < NUM_Q; q++) begin : g_floor
        AST_LEVEL_ABOVE_LOCAL: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> (level_q[q] >= ($past(local_metric) >> LOCAL_SHIFT)));  // R3
    end

endmodule

// File: tb/test_regional_cong_agg.sv
`timescale 1ns/1ps
module test_regional_cong_agg;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] vc_busy = '0;
    logic [8:0]  xb_demand = '0;
    logic [8:0]  nin_n = '0, nin_e = '0, nin_s = '0, nin_w = '0;
    logic [8:0]  thr = '0;
    logic [8:0]  nout_n, nout_e, nout_s, nout_w;
    logic [35:0] quad_level;
    logic [3:0]  quad_hot;

    int n_checks = 0;
    int n_fail   = 0;

    int exp_lvl [4];
    int exp_sb  [4];
    logic [3:0] exp_hot;

    always #2.5 clk = ~clk;

    regional_cong_agg #(
        .VC_PER_PORT (4),
        .NUM_PORTS   (5),
        .XB_W        (9),
        .LOCAL_SHIFT (0),
        .NBR_SHIFT   (1),
        .NBR_PRESENT (4'b0111)
    ) i_regional_cong_agg (
        .clk        (clk),
        .rst        (rst),
        .vc_busy    (vc_busy),
        .xb_demand  (xb_demand),
        .nbr_in_n   (nin_n),
        .nbr_in_e   (nin_e),
        .nbr_in_s   (nin_s),
        .nbr_in_w   (nin_w),
        .threshold  (thr),
        .nbr_out_n  (nout_n),
        .nbr_out_e  (nout_e),
        .nbr_out_s  (nout_s),
        .nbr_out_w  (nout_w),
        .quad_level (quad_level),
        .quad_hot   (quad_hot)
    );

    task automatic chk(string req, string what, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // Expected values from the requirements; west link is absent (R5).
    task automatic compute_expected();
        int loc, n, e, s, w;
        loc = $countones(vc_busy) + int'(xb_demand);
        if (loc > 511) loc = 511;                       // R2 clamp
        n = int'(nin_n); e = int'(nin_e); s = int'(nin_s); w = 0;
        exp_lvl[0] = loc + (imax(n, e) >> 1);           // NE, R3
        exp_lvl[1] = loc + (imax(n, w) >> 1);           // NW
        exp_lvl[2] = loc + (imax(s, w) >> 1);           // SW
        exp_lvl[3] = loc + (imax(s, e) >> 1);           // SE
        for (int q = 0; q < 4; q++) begin
            if (exp_lvl[q] > 511) exp_lvl[q] = 511;     // R4
            exp_hot[q] = (exp_lvl[q] >= int'(thr));     // R7
        end
        exp_sb[0] = imax(exp_lvl[2], exp_lvl[3]);       // R6 north
        exp_sb[1] = imax(exp_lvl[1], exp_lvl[2]);       // east
        exp_sb[2] = imax(exp_lvl[0], exp_lvl[1]);       // south
        exp_sb[3] = imax(exp_lvl[0], exp_lvl[3]);       // west
    endtask

    task automatic check_outputs(string req);
        for (int q = 0; q < 4; q++)
            chk(req, $sformatf("quad_level[%0d]", q), int'(quad_level[q*9 +: 9]), exp_lvl[q]);
        chk("R7", "quad_hot", int'(quad_hot), int'(exp_hot));
        chk("R6", "nbr_out_n", int'(nout_n), exp_sb[0]);
        chk("R6", "nbr_out_e", int'(nout_e), exp_sb[1]);
        chk("R6", "nbr_out_s", int'(nout_s), exp_sb[2]);
        chk("R6", "nbr_out_w", int'(nout_w), exp_sb[3]);
    endtask

    task automatic drive(logic [19:0] vc, logic [8:0] xb, logic [8:0] n,
                         logic [8:0] e, logic [8:0] s, logic [8:0] w, logic [8:0] t);
        @(negedge clk);
        vc_busy = vc; xb_demand = xb;
        nin_n = n; nin_e = e; nin_s = s; nin_w = w; thr = t;
    endtask

    task automatic apply_check(string req, logic [19:0] vc, logic [8:0] xb,
                               logic [8:0] n, logic [8:0] e, logic [8:0] s,
                               logic [8:0] w, logic [8:0] t);
        drive(vc, xb, n, e, s, w, t);
        @(posedge clk);
        @(negedge clk);
        compute_expected();
        check_outputs(req);
    endtask

    // R1: reset dominates busy inputs
    task automatic t_reset();
        rst = 1'b1;
        drive(20'hFFFFF, 9'd77, 9'd300, 9'd300, 9'd300, 9'd300, 9'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R1", "quad_level", int'(quad_level == '0), 1);
        chk("R1", "quad_hot", int'(quad_hot), 0);
        chk("R1", "sideband", int'({nout_n, nout_e, nout_s, nout_w} == '0), 1);
        rst = 1'b0;
    endtask

    // R2, R3: local figure only, then with neighbours in every quadrant
    task automatic t_local_and_quadrants();
        apply_check("R2", 20'h0000F, 9'd7, 9'd0, 9'd0, 9'd0, 9'd0, 9'd511);
        apply_check("R2", 20'hFFFFF, 9'd30, 9'd0, 9'd0, 9'd0, 9'd0, 9'd511);
        apply_check("R3", 20'h00103, 9'd0, 9'd100, 9'd40, 9'd200, 9'd0, 9'd400);
        apply_check("R3", 20'h00000, 9'd5, 9'd10, 9'd250, 9'd90, 9'd0, 9'd100);
    endtask

    // R5: absent west link cannot raise NW or SW
    task automatic t_absent_link();
        apply_check("R5", 20'h00001, 9'd9, 9'd0, 9'd0, 9'd0, 9'd510, 9'd11);
        chk("R5", "NW ignores west", int'(quad_level[17:9]), 10);
        chk("R5", "SW ignores west", int'(quad_level[26:18]), 10);
        chk("R5", "flags ignore west", int'(quad_hot), 0);
    endtask

    // R2 clamp of the local sum, R4 clamp of the merged level
    task automatic t_saturation();
        apply_check("R2", 20'hFFFFF, 9'd500, 9'd0, 9'd0, 9'd0, 9'd0, 9'd511);
        chk("R2", "local clamp SE", int'(quad_level[35:27]), 511);
        apply_check("R4", 20'h00000, 9'd400, 9'd400, 9'd0, 9'd0, 9'd0, 9'd511);
        chk("R4", "NE saturated", int'(quad_level[8:0]), 511);
        chk("R4", "SW unsaturated", int'(quad_level[26:18]), 400);
    endtask

    // R7: inclusive threshold compare
    task automatic t_threshold();
        apply_check("R7", 20'h00000, 9'd100, 9'd60, 9'd0, 9'd20, 9'd0, 9'd130);
        chk("R7", "at level", int'(quad_hot), 4'b0011);
        apply_check("R7", 20'h00000, 9'd100, 9'd60, 9'd0, 9'd20, 9'd0, 9'd131);
        chk("R7", "one above", int'(quad_hot), 4'b0000);
        apply_check("R7", 20'h00000, 9'd100, 9'd60, 9'd0, 9'd20, 9'd0, 9'd110);
        chk("R7", "all hot", int'(quad_hot), 4'b1111);
    endtask

    // R8: one-cycle latency and hold
    task automatic t_latency();
        int old_ne;
        apply_check("R8", 20'h00007, 9'd20, 9'd40, 9'd0, 9'd0, 9'd0, 9'd0);
        old_ne = exp_lvl[0];
        drive(20'h00000, 9'd200, 9'd100, 9'd0, 9'd0, 9'd0, 9'd0);
        #1;
        chk("R8", "before edge", int'(quad_level[8:0]), old_ne);
        @(posedge clk);
        @(negedge clk);
        compute_expected();
        check_outputs("R8");
        @(posedge clk);
        @(negedge clk);
        check_outputs("R8");
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_local_and_quadrants();
        t_absent_link();
        t_saturation();
        t_threshold();
        t_latency();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule